// File: doc/BRIEF.md
# SPI Register-Access Master

This block is the master side of a simple SPI register link. A client hands it one request at a time through a valid/ready handshake. Each request carries a direction flag, a register address and, for writes, one data byte. For every request the block pulls chip-select low and clocks out one fixed frame of 16 SCK pulses, then releases chip-select.

The first byte of the frame is a command byte. Its most significant bit is the direction flag, and the address sits in the bits below it. The second byte is the write data on a write. On a read, the second byte is all ones, and during it the block samples the slave's reply from MISO.

SCK idles low. The rate of SCK is set by a parameter that gives the number of system clocks in each SCK half-period. When the transfer completes, the block raises a one-cycle done pulse, and the read byte is valid in that same cycle. A fixed idle gap with chip-select high separates back-to-back transfers.

Top module: `spi_rw_master`

## Requirements
- R1: While `spi_cs_n` is high, `spi_sck` is low. Each transfer gives exactly 16 SCK pulses (rising then falling) while `spi_cs_n` is low.
- R2: The first frame bit (frame bit 15) is the direction flag, with 1 for a write and 0 for a read. Frame bits 14..8 are `req_addr[6:0]`.
- R3: MOSI sends the frame most-significant bit first. The first bit is on MOSI from the moment `spi_cs_n` falls. Each later bit changes only on a falling SCK edge, so MOSI is stable at every rising edge.
- R4: Frame bits 7..0 are `req_wdata` on a write and all ones on a read. MOSI returns high after the 16th falling edge.
- R5: On a read, MISO is sampled on falling edges 9 to 16, and the sample from edge 9 becomes bit 7 of `rsp_rdata`.
- R6: Each SCK half-period lasts HALF_CLKS clocks. `spi_cs_n` is low for exactly one half-period before the first rising edge and for one half-period after the 16th falling edge, so it is low for 33 half-periods in all.
- R7: `rsp_done` pulses for exactly one cycle, in the cycle where `spi_cs_n` returns high. A read's byte is on `rsp_rdata` in that cycle.
- R8: After `spi_cs_n` rises, `req_ready` stays low for two further half-periods. A `req_valid` presented while the block is busy has no effect on the transfer in progress.
- R9: While `rst` is high, the block is idle with `spi_cs_n` high, `spi_sck` low, `spi_mosi` high, `req_ready` high and `rsp_done` low.
- R10: `req_ready` is high exactly when the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and `spi_cs_n` goes low on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read byte, valid with rsp_done |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |

## Verification
The bench builds the block with HALF_CLKS set to 3, so one full transfer plus its gap takes 105 clocks. This keeps every half-period boundary, the lead and trail half-periods and the two-half-period gap visible within a short run.

A half-period of more than one clock means that a wrong count in the tick counter, or an edge that lands one clock early or late, shifts SCK and MOSI away from the model. The bench drives MISO with random values outside the window in which each reply bit must be sampled, so sampling on the wrong edge corrupts the read byte.

Requests are held valid across a busy transfer, which checks both that they are ignored while busy and that they are taken on the first ready cycle.

// File: rtl/spi_rw_pkg.sv
package spi_rw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_TRAIL = 3'd3,
    ST_GAP   = 3'd4
  } spi_rw_state_t;

  localparam int unsigned GAP_HALVES = 2;
endpackage

// File: rtl/spi_rw_halftick.sv
module spi_rw_halftick #(
  parameter int unsigned HALF_CLKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_rw_shifter.sv
module spi_rw_shifter #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [FRAME_W-1:0] frame,
  input  logic              fall,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx
);
  logic [FRAME_W-1:0] tx;

  assign mosi = tx[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx <= '1;
      rx <= '0;
    end else if (load) begin
      tx <= frame;
    end else if (fall) begin
      tx <= {tx[FRAME_W-2:0], 1'b1};
      rx <= {rx[DATA_W-2:0], miso};
    end
  end
endmodule

// File: rtl/spi_rw_master.sv
module spi_rw_master
  import spi_rw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned HALF_CLKS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int unsigned FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int unsigned FCW     = $clog2(FRAME_W);
  localparam logic [FCW-1:0] LAST_FALL = FCW'(FRAME_W - 1);
  localparam logic [FCW-1:0] LAST_GAP  = FCW'(GAP_HALVES - 1);

  spi_rw_state_t state;
  logic [FCW-1:0] fcnt;
  logic tick;
  logic take;
  logic fall;
  logic [FRAME_W-1:0] frame;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_ready && req_valid;
  assign fall      = (state == ST_SHIFT) && tick && spi_sck;
  assign frame     = {req_write, req_addr, req_write ? req_wdata : {DATA_W{1'b1}}};

  spi_rw_halftick #(.HALF_CLKS(HALF_CLKS)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (state != ST_IDLE),
    .tick (tick)
  );

  spi_rw_shifter #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (take),
    .frame (frame),
    .fall  (fall),
    .miso  (spi_miso),
    .mosi  (spi_mosi),
    .rx    (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      fcnt     <= '0;
      spi_cs_n <= 1'b1;
      spi_sck  <= 1'b0;
      rsp_done <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take) begin
            spi_cs_n <= 1'b0;
            fcnt     <= '0;
            state    <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            spi_sck <= 1'b1;
            state   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            spi_sck <= ~spi_sck;
            if (spi_sck) begin
              if (fcnt == LAST_FALL) begin
                fcnt  <= '0;
                state <= ST_TRAIL;
              end else begin
                fcnt <= fcnt + 1'b1;
              end
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            spi_cs_n <= 1'b1;
            rsp_done <= 1'b1;
            state    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (fcnt == LAST_GAP) begin
              fcnt  <= '0;
              state <= ST_IDLE;
            end else begin
              fcnt <= fcnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_sck_low_idle_R1: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);
  assert_sck_moves_selected_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_sck) |-> !spi_cs_n);
  assert_mosi_stable_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sck) |-> $stable(spi_mosi));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  assert_cs_rise_done_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> rsp_done);
  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> !req_ready);
  assert_gap_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> !req_ready);
  assert_take_selects_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!spi_cs_n && !req_ready));
endmodule

// File: tb/spi_rw_master_bench.sv
`timescale 1ns/1ps
module spi_rw_master_bench;
  localparam int H  = 3;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic spi_miso = 1'b0;
  logic req_ready, rsp_done, spi_cs_n, spi_sck, spi_mosi;
  logic [7:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int t = -1;
  bit exp_ready = 1'b1;
  bit exp_read = 1'b0;
  logic [FW-1:0] exp_frame = '1;
  logic [7:0] cur_reply = '0;
  logic [7:0] next_reply = '0;

  always #2.5 clk = ~clk;

  spi_rw_master #(.ADDR_W(7), .DATA_W(8), .HALF_CLKS(H)) u_spi_rw_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at t=%0d: got %0h expected %0h", req, what, t, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic step();
    bit e_cs, e_sck, e_mosi, e_done;
    @(negedge clk);
    if (req_valid && exp_ready) begin
      t = 0;
      exp_frame = {req_write, req_addr, req_write ? req_wdata : 8'hFF};
      exp_read  = !req_write;
      cur_reply = next_reply;
    end else if (t >= 0) begin
      t++;
    end
    if (t == 35 * H) t = -1;
    exp_ready = (t < 0);
    e_cs   = (t < 0) || (t >= 33 * H);
    e_sck  = (t >= H && t < 33 * H) ? bit'((t / H) % 2) : 1'b0;
    e_mosi = (t >= 0 && t < 32 * H) ? exp_frame[FW - 1 - t / (2 * H)] : 1'b1;
    e_done = (t == 33 * H);
    chk(spi_cs_n == e_cs, "R6", "spi_cs_n", int'(spi_cs_n), int'(e_cs));
    chk(spi_sck == e_sck, "R1", "spi_sck", int'(spi_sck), int'(e_sck));
    if (t >= 0 && t < 2 * H)
      chk(spi_mosi == e_mosi, "R2", "spi_mosi", int'(spi_mosi), int'(e_mosi));
    else if (t >= 0 && t < 16 * H)
      chk(spi_mosi == e_mosi, "R3", "spi_mosi", int'(spi_mosi), int'(e_mosi));
    else
      chk(spi_mosi == e_mosi, "R4", "spi_mosi", int'(spi_mosi), int'(e_mosi));
    if (t >= 33 * H)
      chk(req_ready == exp_ready, "R8", "req_ready", int'(req_ready), int'(exp_ready));
    else
      chk(req_ready == exp_ready, "R10", "req_ready", int'(req_ready), int'(exp_ready));
    chk(rsp_done == e_done, "R7", "rsp_done", int'(rsp_done), int'(e_done));
    if (e_done && exp_read)
      chk(rsp_rdata == cur_reply, "R5", "rsp_rdata", int'(rsp_rdata), int'(cur_reply));
    if (t >= 17 * H && t < 32 * H)
      spi_miso = cur_reply[7 - (t - 17 * H) / (2 * H)];
    else
      spi_miso = 1'($urandom % 2);
  endtask

  task automatic issue(input bit w, input logic [6:0] a, input logic [7:0] d,
                       input logic [7:0] r);
    req_write  = w;
    req_addr   = a;
    req_wdata  = d;
    next_reply = r;
    req_valid  = 1'b1;
    do step(); while (t != 0);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    do step(); while (t >= 0);
    repeat (3) step();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9: idle state held by reset
    chk(spi_cs_n == 1'b1, "R9", "spi_cs_n", int'(spi_cs_n), 1);
    chk(spi_sck == 1'b0, "R9", "spi_sck", int'(spi_sck), 0);
    chk(spi_mosi == 1'b1, "R9", "spi_mosi", int'(spi_mosi), 1);
    chk(req_ready == 1'b1, "R9", "req_ready", int'(req_ready), 1);
    chk(rsp_done == 1'b0, "R9", "rsp_done", int'(rsp_done), 0);
    rst = 1'b0;
    repeat (3) step();
    issue(1'b1, 7'h01, 8'h04, 8'h00);
    drain();
    issue(1'b0, 7'h01, 8'h00, 8'hA5);
    drain();
    // back-to-back: second request held valid while busy (R8, R10)
    issue(1'b1, 7'h7F, 8'hFF, 8'h00);
    issue(1'b0, 7'h00, 8'h12, 8'h3C);
    issue(1'b0, 7'h55, 8'h00, 8'h00);
    drain();
    issue(1'b0, 7'h2A, 8'h00, 8'hFF);
    issue(1'b1, 7'h00, 8'h00, 8'h00);
    issue(1'b0, 7'h63, 8'hC3, 8'h5A);
    drain();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule